// File: doc/BRIEF.md
# Reconfigurable Fixed-Point Lane Pipeline

This block is one lane of a vector arithmetic unit. A single pass through it runs a fixed chain of stages on two 32-bit operands: a bitwise logic unit, a left shifter, an adder or signed 16x16 multiplier (or a signed compare), a right shifter with selectable rounding, a saturating clipper and a conditional write. A 20-bit configuration word travels with each operand pair and selects what every stage does. A stage that is not selected hands its input on unchanged, so one word can describe anything from a plain copy to six chained operations.

The lane accepts one operation per clock when `in_valid` is high and returns the result with a write enable three cycles after the issue cycle. The adder and multiplier stage works at 33 bits, so the sum of two 32-bit values keeps its carry until the right shift and the clipper bring it back to range. A sticky flag records that some result was clipped; only a pulse on `sat_clr` clears it.

Top module: `fxl_pipe`

## Requirements
- R1: With the configuration word all zero, `out_data` equals `in_a` and `out_wr` is 1. Field layout of `in_cfg`: [19:18] logic op, [17:13] left shift, [12:11] arithmetic op, [10:5] right shift, [4:3] rounding mode, [2:1] clip width, [0] conditional write.
- R2: An operation sampled with `in_valid` at rising edge n appears with `out_valid` high after edge n+3; operations leave in issue order, one per accepted input.
- R3: Logic op code 0 passes `in_a`, 1 gives `in_a & in_b`, 2 gives `in_a | in_b`, 3 gives `in_a ^ in_b`.
- R4: The logic result is shifted left by the 5-bit left-shift amount, keeping the low 32 bits.
- R5: Arithmetic op 0 passes the shifted value sign-extended to 33 bits; 1 adds `in_b` in 33 bits; 2 multiplies the signed low 16 bits of the shifted value by the signed low 16 bits of `in_b`; 3 yields 1 when signed `in_a` is less than signed `in_b`, else 0.
- R6: The 33-bit value is shifted right arithmetically by 0 to 63 places; rounding mode 0 rounds toward minus infinity, 1 toward zero, 2 to nearest with ties away from zero, 3 to nearest with ties to even.
- R7: A right shift of zero leaves the value unchanged in all four rounding modes.
- R8: Clip code 1 saturates to the signed 8-bit range, 2 to signed 16-bit, 3 to signed 32-bit; code 0 keeps the low 32 bits without saturation.
- R9: With the conditional-write bit set, `out_wr` is 1 only when `in_cond` is greater than zero as a signed number; with it clear, every valid result is written.
- R10: `out_sat` becomes 1 together with the output of a result whose value the clipper changed, stays 1 until `sat_clr` is sampled high, and reads 0 after reset.
- R11: `out_wr` is 0 in every cycle where `out_valid` is 0, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_cfg | input | 20 | Per-operation configuration word |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_cond | input | 32 | Condition element for the conditional write |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result strobe |
| out_wr | output | 1 | Write enable for the destination element |
| out_data | output | 32 | Result element |
| out_sat | output | 1 | Sticky saturation flag |

## Verification
The assertions watch, on every cycle, the three-cycle latency of the strobe, that a write never appears without a result, that a blocked conditional write stays blocked, that the saturation flag only rises with a result and holds until cleared, that 8-bit clipped and compare results stay in range, and that an all-pass word or a zero right shift returns the first operand exactly. The numerical content of rounding ties, 33-bit carries, multiplier sign handling and clip boundaries can only be shown by the bench's scenarios, which compare every result against a model that computes rounding from the remainder rather than from bit tests.

// File: rtl/fxl_pkg.sv
package fxl_pkg;
  localparam int LANE_W = 32;
  localparam int LSH_W  = $clog2(LANE_W);
  localparam int RSH_W  = LSH_W + 1;

  typedef enum logic [1:0] {LG_PASS = 2'd0, LG_AND = 2'd1, LG_OR = 2'd2, LG_XOR = 2'd3} lg_op_e;
  typedef enum logic [1:0] {AR_PASS = 2'd0, AR_ADD = 2'd1, AR_MUL = 2'd2, AR_SLT = 2'd3} ar_op_e;
  typedef enum logic [1:0] {RN_FLOOR = 2'd0, RN_ZERO = 2'd1, RN_AWAY = 2'd2, RN_EVEN = 2'd3} rn_mode_e;
  typedef enum logic [1:0] {CL_NONE = 2'd0, CL_8 = 2'd1, CL_16 = 2'd2, CL_32 = 2'd3} cl_sel_e;

  typedef struct packed {
    lg_op_e             lg;
    logic [LSH_W-1:0]   lsh;
    ar_op_e             ar;
    logic [RSH_W-1:0]   rsh;
    rn_mode_e           rn;
    cl_sel_e            cl;
    logic               cmov;
  } lane_cfg_t;

  localparam int CFG_W = $bits(lane_cfg_t);
endpackage

// File: rtl/fxl_front.sv
module fxl_front
  import fxl_pkg::*;
#(
  parameter int DW = LANE_W
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  lane_cfg_t     cfg,
  output logic [DW:0]   mid
);
  localparam int HW = DW / 2;

  logic [DW-1:0] lg_v;
  logic [DW-1:0] sh_v;
  logic [DW-1:0] prod;

  always_comb begin
    unique case (cfg.lg)
      LG_AND:  lg_v = a & b;
      LG_OR:   lg_v = a | b;
      LG_XOR:  lg_v = a ^ b;
      default: lg_v = a;
    endcase

    sh_v = lg_v << cfg.lsh;

    prod = $signed({{HW{sh_v[HW-1]}}, sh_v[HW-1:0]}) *
           $signed({{HW{b[HW-1]}}, b[HW-1:0]});

    unique case (cfg.ar)
      AR_ADD:  mid = {sh_v[DW-1], sh_v} + {b[DW-1], b};
      AR_MUL:  mid = {prod[DW-1], prod};
      AR_SLT:  mid = {{DW{1'b0}}, ($signed(a) < $signed(b))};
      default: mid = {sh_v[DW-1], sh_v};
    endcase
  end
endmodule

// File: rtl/fxl_rshift.sv
module fxl_rshift
  import fxl_pkg::*;
#(
  parameter int DW = LANE_W,
  parameter int SW = RSH_W
) (
  input  logic [DW:0]   v,
  input  logic [SW-1:0] sh,
  input  rn_mode_e      mode,
  output logic [DW+1:0] r
);
  localparam int MW = DW + 1;
  localparam int RW = MW + 1;
  localparam int EW = 2 ** SW;
  localparam logic [EW-1:0] ONE_E = {{(EW-1){1'b0}}, 1'b1};

  logic [EW-1:0]        ve;
  logic [EW-1:0]        msk;
  logic signed [RW-1:0] vx;
  logic signed [RW-1:0] q;
  logic [SW-1:0]        idx;
  logic                 frac, below, half, neg, inc;

  always_comb begin
    ve    = {{(EW-MW){v[MW-1]}}, v};
    msk   = (ONE_E << sh) - ONE_E;
    frac  = |(ve & msk);
    below = |(ve & (msk >> 1));
    idx   = sh - SW'(1);
    half  = (sh != '0) && ve[idx];
    neg   = v[MW-1];
    vx    = {v[MW-1], v};
    q     = vx >>> sh;

    unique case (mode)
      RN_ZERO: inc = neg & frac;
      RN_AWAY: inc = half & (below | ~neg);
      RN_EVEN: inc = half & (below | q[0]);
      default: inc = 1'b0;
    endcase

    r = q + {{(RW-1){1'b0}}, inc};
  end
endmodule

// File: rtl/fxl_clip.sv
module fxl_clip
  import fxl_pkg::*;
#(
  parameter int DW = LANE_W
) (
  input  logic [DW+1:0] r,
  input  cl_sel_e       sel,
  output logic [DW-1:0] q,
  output logic          sat
);
  localparam int RW = DW + 2;
  localparam logic signed [RW-1:0] ONE_R = {{(RW-1){1'b0}}, 1'b1};

  int                   lim_w;
  logic signed [RW-1:0] hi, lo, rs;

  always_comb begin
    unique case (sel)
      CL_8:    lim_w = 8;
      CL_16:   lim_w = 16;
      default: lim_w = DW;
    endcase
    hi = (ONE_R <<< (lim_w - 1)) - ONE_R;
    lo = -hi - ONE_R;
    rs = r;

    if (sel == CL_NONE) begin
      q   = r[DW-1:0];
      sat = 1'b0;
    end else if (rs > hi) begin
      q   = hi[DW-1:0];
      sat = 1'b1;
    end else if (rs < lo) begin
      q   = lo[DW-1:0];
      sat = 1'b1;
    end else begin
      q   = r[DW-1:0];
      sat = 1'b0;
    end
  end
endmodule

// File: rtl/fxl_pipe.sv
module fxl_pipe
  import fxl_pkg::*;
#(
  parameter int DW          = LANE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CFG_W-1:0] in_cfg,
  input  logic [DW-1:0]    in_a,
  input  logic [DW-1:0]    in_b,
  input  logic [DW-1:0]    in_cond,
  input  logic             sat_clr,
  output logic             out_valid,
  output logic             out_wr,
  output logic [DW-1:0]    out_data,
  output logic             out_sat
);
  localparam int MW = DW + 1;
  localparam int RW = DW + 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_pipe[SYNC_STAGES-1];

  // stage R: operand capture
  logic          v1;
  lane_cfg_t     cfg1;
  logic [DW-1:0] a1, b1, c1;

  // stage X1: front result
  logic          v2;
  lane_cfg_t     cfg2;
  logic [MW-1:0] mid2;
  logic [DW-1:0] c2;

  // stage X2: rounded result
  logic          v3;
  cl_sel_e       cl3;
  logic          cmov3;
  logic [RW-1:0] rnd3;
  logic [DW-1:0] c3;

  // stage W
  logic          v4, wr4, sat4;
  logic [DW-1:0] d4;

  // combinational stage outputs
  logic [MW-1:0] mid_d;
  logic [RW-1:0] rnd_d;
  logic [DW-1:0] clip_d;
  logic          clip_sat;
  logic          wr_d;
  logic          sat_d;

  fxl_front #(.DW(DW)) i_front (
    .a   (a1),
    .b   (b1),
    .cfg (cfg1),
    .mid (mid_d)
  );

  fxl_rshift #(.DW(DW), .SW(RSH_W)) i_rshift (
    .v    (mid2),
    .sh   (cfg2.rsh),
    .mode (cfg2.rn),
    .r    (rnd_d)
  );

  fxl_clip #(.DW(DW)) i_clip (
    .r   (rnd3),
    .sel (cl3),
    .q   (clip_d),
    .sat (clip_sat)
  );

  always_comb begin
    wr_d  = v3 & (~cmov3 | ($signed(c3) > 0));
    sat_d = (sat4 & ~sat_clr) | (v3 & clip_sat);
  end

  // valid chain and sticky flag
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      v1   <= 1'b0;
      v2   <= 1'b0;
      v3   <= 1'b0;
      v4   <= 1'b0;
      wr4  <= 1'b0;
      sat4 <= 1'b0;
    end else begin
      v1   <= in_valid;
      v2   <= v1;
      v3   <= v2;
      v4   <= v3;
      wr4  <= wr_d;
      sat4 <= sat_d;
    end
  end

  // data registers, each loaded only when its stage holds an operation
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cfg1 <= '0;
      a1   <= '0;
      b1   <= '0;
      c1   <= '0;
    end else if (in_valid) begin
      cfg1 <= lane_cfg_t'(in_cfg);
      a1   <= in_a;
      b1   <= in_b;
      c1   <= in_cond;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cfg2 <= '0;
      mid2 <= '0;
      c2   <= '0;
    end else if (v1) begin
      cfg2 <= cfg1;
      mid2 <= mid_d;
      c2   <= c1;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cl3   <= CL_NONE;
      cmov3 <= 1'b0;
      rnd3  <= '0;
      c3    <= '0;
    end else if (v2) begin
      cl3   <= cfg2.cl;
      cmov3 <= cfg2.cmov;
      rnd3  <= rnd_d;
      c3    <= c2;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)  d4 <= '0;
    else if (v3) d4 <= clip_d;
  end

  assign out_valid = v4;
  assign out_wr    = wr4;
  assign out_data  = d4;
  assign out_sat   = sat4;
endmodule

// File: rtl/fxl_pipe_chk.sv
module fxl_pipe_chk
  import fxl_pkg::*;
#(
  parameter int DW = LANE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [CFG_W-1:0] in_cfg,
  input logic [DW-1:0]    in_a,
  input logic [DW-1:0]    in_cond,
  input logic             sat_clr,
  input logic             out_valid,
  input logic             out_wr,
  input logic [DW-1:0]    out_data,
  input logic             out_sat
);
  localparam logic [CFG_W-1:0] RN_MASK = CFG_W'(2'b11) << 3;

  logic [2:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm_cnt <= '0;
    else if (warm_cnt < 6) warm_cnt <= warm_cnt + 3'd1;
  end
  assign warm = (warm_cnt == 3'd6);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 4)));

  p_wr_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> out_valid);

  p_cmov_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 4) && $past(in_cfg[0], 4) && !($signed($past(in_cond, 4)) > 0))
      |-> !out_wr);

  p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_sat) && !$past(sat_clr)) |-> out_sat);

  p_sat_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_sat) |-> out_valid);

  p_clip8_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 4) && ($past(in_cfg[2:1], 4) == 2'b01))
      |-> (($signed(out_data) <= 127) && ($signed(out_data) >= -128)));

  p_slt_bool_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 4) && ($past(in_cfg[12:11], 4) == 2'b11))
      |-> (out_data <= DW'(1)));

  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 4) && ($past(in_cfg, 4) == '0))
      |-> (out_wr && (out_data == $past(in_a, 4))));

  p_rsh0_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 4) && (($past(in_cfg, 4) & ~RN_MASK) == '0))
      |-> (out_data == $past(in_a, 4)));
endmodule

bind fxl_pipe fxl_pipe_chk #(.DW(DW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .in_valid  (in_valid),
  .in_cfg    (in_cfg),
  .in_a      (in_a),
  .in_cond   (in_cond),
  .sat_clr   (sat_clr),
  .out_valid (out_valid),
  .out_wr    (out_wr),
  .out_data  (out_data),
  .out_sat   (out_sat)
);

// File: tb/test_fxl_pipe.sv
`timescale 1ns/1ps
module test_fxl_pipe;
  localparam int N_RAND = 3000;
  localparam int QN     = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [19:0] in_cfg = '0;
  logic [31:0] in_a = '0, in_b = '0, in_cond = '0;
  logic        sat_clr = 1'b0;
  logic        out_valid, out_wr, out_sat;
  logic [31:0] out_data;

  int checks = 0;
  int failures = 0;
  int wr_idx = 0;
  int rd_idx = 0;
  bit mon_en = 1'b0;
  bit mdl_sat = 1'b0;
  bit done = 1'b0;

  logic [31:0] exp_d [QN];
  bit          exp_w [QN];
  bit          exp_s [QN];
  string       exp_t [QN];

  always #4 clk = ~clk;

  fxl_pipe i_fxl_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cfg(in_cfg),
    .in_a(in_a), .in_b(in_b), .in_cond(in_cond), .sat_clr(sat_clr),
    .out_valid(out_valid), .out_wr(out_wr), .out_data(out_data), .out_sat(out_sat)
  );

  function automatic logic [19:0] mk(int lg, int lsh, int ar, int rsh, int rn, int cl, int cm);
    return {lg[1:0], lsh[4:0], ar[1:0], rsh[5:0], rn[1:0], cl[1:0], cm[0]};
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // reference model, written from the requirements
  task automatic model(input logic [31:0] a, b, c, input logic [19:0] cfg,
                       output logic [31:0] d, output bit w, output bit s);
    logic [31:0] x;
    longint v, q, p, f, r, hi, lo, cl_v;
    int s_amt;
    case (cfg[19:18])
      2'd1: x = a & b;
      2'd2: x = a | b;
      2'd3: x = a ^ b;
      default: x = a;
    endcase
    x = x << cfg[17:13];
    case (cfg[12:11])
      2'd1: v = longint'($signed(x)) + longint'($signed(b));
      2'd2: v = longint'($signed(x[15:0])) * longint'($signed(b[15:0]));
      2'd3: v = ($signed(a) < $signed(b)) ? 64'sd1 : 64'sd0;
      default: v = longint'($signed(x));
    endcase
    s_amt = int'(cfg[10:5]);
    if (s_amt == 0) r = v;
    else if (s_amt >= 40) r = (cfg[4:3] == 2'd0 && v < 0) ? -64'sd1 : 64'sd0;
    else begin
      p = 64'sd1 <<< s_amt;
      q = v >>> s_amt;
      f = v - q * p;
      r = q;
      case (cfg[4:3])
        2'd1: if (v < 0 && f != 0) r = q + 1;
        2'd2: if (2 * f > p || (2 * f == p && v >= 0)) r = q + 1;
        2'd3: if (2 * f > p || (2 * f == p && q[0])) r = q + 1;
        default: r = q;
      endcase
    end
    case (cfg[2:1])
      2'd1: begin hi = 127; lo = -128; end
      2'd2: begin hi = 32767; lo = -32768; end
      default: begin hi = 64'sd2147483647; lo = -64'sd2147483648; end
    endcase
    if (cfg[2:1] == 2'd0) begin
      d = r[31:0];
      s = 1'b0;
    end else begin
      cl_v = (r > hi) ? hi : ((r < lo) ? lo : r);
      d = cl_v[31:0];
      s = (cl_v != r);
    end
    w = !cfg[0] || ($signed(c) > 0);
  endtask

  task automatic issue(logic [31:0] a, b, c, logic [19:0] cfg, string tag);
    logic [31:0] d; bit w, s;
    @(negedge clk);
    model(a, b, c, cfg, d, w, s);
    exp_d[wr_idx % QN] = d;
    exp_w[wr_idx % QN] = w;
    exp_s[wr_idx % QN] = s;
    exp_t[wr_idx % QN] = tag;
    wr_idx++;
    in_a = a; in_b = b; in_cond = c; in_cfg = cfg; in_valid = 1'b1;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_cfg = $urandom;
      in_a = $urandom;
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        string t;
        t = exp_t[rd_idx % QN];
        check(out_data == exp_d[rd_idx % QN], t, "data", longint'(out_data), longint'(exp_d[rd_idx % QN]));
        check(out_wr == exp_w[rd_idx % QN], "R9", "write enable", longint'(out_wr), longint'(exp_w[rd_idx % QN]));
        mdl_sat = mdl_sat | exp_s[rd_idx % QN];
        check(out_sat == mdl_sat, "R10", "sticky flag", longint'(out_sat), longint'(mdl_sat));
        rd_idx++;
      end else begin
        check(out_wr == 1'b0, "R11", "idle write", longint'(out_wr), 0);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", rd_idx, wr_idx);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R2", "reset valid", longint'(out_valid), 0);
    check(out_wr == 1'b0, "R11", "reset write", longint'(out_wr), 0);
    check(out_sat == 1'b0, "R10", "reset flag", longint'(out_sat), 0);
    mon_en = 1'b1;

    // pass-through and stage ops
    issue(32'hDEADBEEF, 32'h12345678, 0, mk(0,0,0,0,0,0,0), "R1");
    issue(32'hF0F0_1234, 32'h0FF0_FF00, 0, mk(1,0,0,0,0,0,0), "R3");
    issue(32'hF0F0_1234, 32'h0FF0_FF00, 0, mk(2,0,0,0,0,0,0), "R3");
    issue(32'hF0F0_1234, 32'h0FF0_FF00, 0, mk(3,0,0,0,0,0,0), "R3");
    issue(32'h0F00_00F1, 0, 0, mk(0,4,0,0,0,0,0), "R4");
    issue(32'h0000_0003, 0, 0, mk(0,31,0,0,0,0,0), "R4");
    issue(32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, mk(0,0,1,1,0,0,0), "R5");
    issue(32'hAAAA_8000, 32'h5555_8000, 0, mk(0,0,2,0,0,0,0), "R5");
    issue(32'h0000_7FFF, 32'hFFFF_FFFE, 0, mk(0,0,2,0,0,0,0), "R5");
    issue(32'hFFFF_FFFF, 32'h0000_0001, 0, mk(0,0,3,0,0,0,0), "R5");
    issue(32'h0000_0005, 32'h0000_0003, 0, mk(0,0,3,0,0,0,0), "R5");
    // rounding of -2.5, 3.5, 1.5, 2.5 and a full-width shift
    for (int m = 0; m < 4; m++) begin
      issue(-32'sd5, 0, 0, mk(0,0,0,1,m,0,0), "R6");
      issue(32'd7, 0, 0, mk(0,0,0,1,m,0,0), "R6");
      issue(32'd6, 0, 0, mk(0,0,0,2,m,0,0), "R6");
      issue(32'd10, 0, 0, mk(0,0,0,2,m,0,0), "R6");
      issue(32'hFFFF_FFFF, 0, 0, mk(0,0,0,63,m,0,0), "R6");
      issue(-32'sd7, 0, 0, mk(0,0,0,0,m,0,0), "R7");
    end
    // conditional write
    issue(32'd9, 0, 32'd0, mk(0,0,0,0,0,0,1), "R9");
    issue(32'd9, 0, 32'd5, mk(0,0,0,0,0,0,1), "R9");
    issue(32'd9, 0, 32'hFFFF_FFFF, mk(0,0,0,0,0,0,1), "R9");
    issue(32'd9, 0, 32'hFFFF_FFFF, mk(0,0,0,0,0,0,0), "R9");
    // clipping, without then with saturation
    issue(32'd127, 0, 0, mk(0,0,0,0,0,1,0), "R8");
    issue(32'h7FFF_FFFF, 32'd1, 0, mk(0,0,1,0,0,0,0), "R8");
    idle(6);
    check(out_sat == 1'b0, "R10", "flag before clip", longint'(out_sat), 0);
    issue(32'd300, 0, 0, mk(0,0,0,0,0,1,0), "R8");
    issue(-32'sd300, 0, 0, mk(0,0,0,0,0,1,0), "R8");
    issue(32'd40000, 0, 0, mk(0,0,0,0,0,2,0), "R8");
    issue(32'h7FFF_FFFF, 32'd1, 0, mk(0,0,1,0,0,3,0), "R8");
    issue(32'd5, 0, 0, mk(0,0,0,0,0,0,0), "R10");
    idle(8);
    check(out_sat == 1'b1, "R10", "flag held", longint'(out_sat), 1);
    @(negedge clk); sat_clr = 1'b1; mdl_sat = 1'b0;
    @(negedge clk); sat_clr = 1'b0;
    check(out_sat == 1'b0, "R10", "flag cleared", longint'(out_sat), 0);

    // random mix
    for (int i = 0; i < N_RAND; i++) begin
      logic [19:0] cfg;
      logic [31:0] c;
      int rs, sel;
      if ($urandom_range(0, 4) == 0) idle(1);
      sel = $urandom_range(0, 3);
      rs = (sel == 0) ? 0 : ((sel == 3) ? $urandom_range(40, 63) : $urandom_range(1, 39));
      cfg = mk($urandom_range(0,3), ($urandom_range(0,1) == 0) ? 0 : $urandom_range(0,31),
               $urandom_range(0,3), rs, $urandom_range(0,3), $urandom_range(0,3),
               $urandom_range(0,1));
      case ($urandom_range(0, 3))
        0: c = 0;
        1: c = 1;
        2: c = 32'hFFFF_FFFF;
        default: c = $urandom;
      endcase
      issue($urandom, $urandom, c, cfg, "R6");
      if (i == N_RAND / 2) begin
        idle(6);
        @(negedge clk); sat_clr = 1'b1; mdl_sat = 1'b0;
        @(negedge clk); sat_clr = 1'b0;
        check(out_sat == 1'b0, "R10", "flag cleared mid-run", longint'(out_sat), 0);
      end
    end
    idle(10);
    check(rd_idx == wr_idx, "R2", "result count", longint'(rd_idx), longint'(wr_idx));
    done = 1'b1;
    finish_run();
  end
endmodule